// File: doc/BRIEF.md
# Test Access Port with Field-Coded Instruction Register

This block is a boundary-scan test access port controller. It follows the standard sixteen-state TAP sequencer and is clocked by the test clock. It carries a 25-bit instruction register. That register is not one opaque opcode. It is a set of fields:

| Bits | Field |
|------|-------|
| 24 | special-register flag (low = internal scan chain) |
| 23:18 | user select |
| 17:16 | upper self-test enable bits |
| 15:13 | clock ratio (active low) |
| 12 | freeze |
| 11:10 | setup mode (active low) |
| 9:7 | lower self-test enable bits |
| 6 | scan test mode (active low) |
| 5 | disable all outputs (active low) |
| 4 | boundary cells drive the pads (active low) |
| 3 | boundary cells drive the core inputs (active low) |
| 2:0 | chain-wiring opcode |

A full instruction code chooses one data register from a small fixed set. Separately, bits 6, 5, 4 and 3 are latched and driven out as active-low chip-test controls.

The data registers are:
- bypass;
- a 32-bit identification register;
- an 8-bit read-only revision register;
- an 8-bit read/write mode register;
- a 1-bit register used with the output-disable instruction;
- a 29-bit self-test data register;
- a 441-bit parallel scan register.

The self-test and parallel scan registers stand in for real chip structures. Each is a plain loopback register: Update-DR stores the shifted value, and Capture-DR returns it.

Test data out changes on the falling edge of the test clock. Its enable is high only while shifting. All shifting is least-significant bit first.

Top module: `jtag_field_tap`

## Requirements
- R1: While `trst_n` is low, the instruction register holds 25'h1FFFFFE and all active-low control outputs are high. After release, a data scan returns 32'h0D5A1003, and `tdo_oe` stays low outside shift states.
- R2: Five consecutive test clocks with `tms` high, from any state, reach Test-Logic-Reset. This restores instruction 25'h1FFFFFE and releases every control output.
- R3: Capture-IR loads 25'h0000001 into the instruction shifter, so bits 1:0 read 01 and all other bits read 0. Shifting presents bit 0 first.
- R4: `tdo_oe` is high exactly in Shift-IR and Shift-DR. `tdo` is updated on the falling edge of `tck`, least-significant bit first.
- R5: Instruction 25'h1FFFFFF selects a 1-bit bypass register that captures 0. The same applies to any unlisted code, including any code whose bit 24 is low.
- R6: Instruction 25'h1FFFFFE selects a 32-bit register that captures 32'h0D5A1003.
- R7: Instruction 25'h127FFFA selects an 8-bit register that always captures 8'h10 (major revision in bits 7:4, minor in bits 3:0). Data shifted into it is ignored.
- R8: Instruction 25'h123FFFA selects an 8-bit register that resets to 0, loads at Update-DR and returns its stored value at Capture-DR.
- R9: Instruction 25'h1FFFFDF selects a 1-bit register capturing 0. Because its bit 5 is low, it drives `out_dis_n` low and `tristate_all` high.
- R10: Instruction 25'h1FFFFFD selects a 29-bit loopback register, and 25'h1FFFEB0 a 441-bit one. Each resets to 0, loads at Update-DR and returns its contents at the next Capture-DR.
- R11: `test_mode_n`, `out_dis_n`, `pad_bscan_n` and `core_bscan_n` follow the latched instruction bits 6, 5, 4 and 3. They change only when Update-IR completes, and they are held high in Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select, sampled on rising `tck` |
| tdi | input | 1 | Test data in, sampled on rising `tck` |
| tdo | output | 1 | Test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo` |
| test_mode_n | output | 1 | Scan test mode, active low (instruction bit 6) |
| out_dis_n | output | 1 | Disable all outputs, active low (instruction bit 5) |
| pad_bscan_n | output | 1 | Boundary cells drive the pads, active low (instruction bit 4) |
| core_bscan_n | output | 1 | Boundary cells drive the core inputs, active low (instruction bit 3) |
| tristate_all | output | 1 | Active-high request to float all chip outputs |

## Verification
A wrong sequencer state shows up within one falling edge: `tdo_oe` rises or falls out of step with the scan, or a scan of the wrong length shifts data by a visible number of bits. A wrong instruction latch reaches the control pins on the same edge it occurs. It also picks the wrong data register, which the next data scan reveals through the captured value or the bypass delay of one bit. A loopback register that loses its contents is caught by the next scan of that register, because every scan returns the value that the previous scan stored.

// File: rtl/tap_fld_pkg.sv
`timescale 1ns/1ps
package tap_fld_pkg;

   typedef enum logic [3:0] {
      ST_TLR, ST_RTI,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PA_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PA_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [2:0] {
      DSEL_BYPASS, DSEL_IDENT, DSEL_REV, DSEL_MODE, DSEL_HIZ, DSEL_SELFTEST, DSEL_PARSCAN
   } dr_sel_e;

   localparam int IR_W = 25;

   // field positions
   localparam int B_SPECIAL  = 24;
   localparam int B_TEST_N   = 6;
   localparam int B_OUTDIS_N = 5;
   localparam int B_PAD_N    = 4;
   localparam int B_CORE_N   = 3;

   localparam logic [IR_W-1:0] OP_BYPASS   = 25'h1FFFFFF;
   localparam logic [IR_W-1:0] OP_IDENT    = 25'h1FFFFFE;
   localparam logic [IR_W-1:0] OP_REV      = 25'h127FFFA;
   localparam logic [IR_W-1:0] OP_MODE     = 25'h123FFFA;
   localparam logic [IR_W-1:0] OP_HIZ      = 25'h1FFFFDF;
   localparam logic [IR_W-1:0] OP_SELFTEST = 25'h1FFFFFD;
   localparam logic [IR_W-1:0] OP_PARSCAN  = 25'h1FFFEB0;

   function automatic dr_sel_e decode_ir(input logic [IR_W-1:0] ir);
      dr_sel_e s;
      s = DSEL_BYPASS;
      if (ir[B_SPECIAL]) begin
         case (ir)
            OP_IDENT:    s = DSEL_IDENT;
            OP_REV:      s = DSEL_REV;
            OP_MODE:     s = DSEL_MODE;
            OP_HIZ:      s = DSEL_HIZ;
            OP_SELFTEST: s = DSEL_SELFTEST;
            OP_PARSCAN:  s = DSEL_PARSCAN;
            default:     s = DSEL_BYPASS;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
   import tap_fld_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   tap_state_e nxt;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
         ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  nxt = tms ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
         ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
         ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  nxt = tms ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
         default:   nxt = ST_TLR;
      endcase
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_TLR;
      else         state <= nxt;
   end

   // run of consecutive tms-high clocks, saturating at five
   logic [2:0] hi_run;
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         hi_run <= 3'd0;
      else if (!tms)       hi_run <= 3'd0;
      else if (hi_run < 5) hi_run <= hi_run + 3'd1;
   end

   AST_TMS_RESET: assert property (@(posedge tck) disable iff (!trst_n)
      (hi_run == 3'd5) |-> (state == ST_TLR)); // R2

endmodule

// File: rtl/tap_ir.sv
`timescale 1ns/1ps
module tap_ir
   import tap_fld_pkg::*;
#(
   parameter int              W       = IR_W,
   parameter logic [W-1:0]    CAP_PAT = 25'h0000001,
   parameter logic [W-1:0]    RST_OP  = OP_IDENT
)(
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_e state,
   input  logic       tdi,
   output logic       sh_lsb,
   output logic [W-1:0] ir_q,
   output dr_sel_e    sel
);

   if (W != IR_W) begin : g_bad_width
      $error("tap_ir: field layout needs a %0d-bit register", IR_W);
   end
   if (CAP_PAT[1:0] != 2'b01) begin : g_bad_cap
      $error("tap_ir: capture pattern must end in 01");
   end

   logic [W-1:0] sh_q;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 sh_q <= '0;
      else if (state == ST_CAP_IR) sh_q <= CAP_PAT;
      else if (state == ST_SH_IR)  sh_q <= {tdi, sh_q[W-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_q <= RST_OP;
      else if (state == ST_TLR)    ir_q <= RST_OP;
      else if (state == ST_UPD_IR) ir_q <= sh_q;
   end

   assign sh_lsb = sh_q[0];
   assign sel    = decode_ir(ir_q);

   AST_IR_CHANGE_AT_UPDATE: assert property (@(posedge tck) disable iff (!trst_n)
      !$stable(ir_q) |-> ($past(state) == ST_UPD_IR || $past(state) == ST_TLR)); // R11

   AST_TLR_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_TLR) |=> (ir_q == RST_OP)); // R1

endmodule

// File: rtl/tap_dr_path.sv
`timescale 1ns/1ps
module tap_dr_path
   import tap_fld_pkg::*;
#(
   parameter logic [31:0] IDENT_VAL  = 32'h0D5A1003,
   parameter int          REV_W      = 8,
   parameter logic [REV_W-1:0] REV_VAL = 8'h10,
   parameter int          MODE_W     = 8,
   parameter int          SELFTEST_W = 29,
   parameter int          PARSCAN_W  = 441,
   parameter bit          HOLD_PARSCAN = 1'b1
)(
   input  logic       tck,
   input  logic       trst_n,
   input  tap_state_e state,
   input  dr_sel_e    sel,
   input  logic       tdi,
   output logic       sh_lsb
);

   localparam int ID_W = 32;
   localparam int M1   = (ID_W > REV_W) ? ID_W : REV_W;
   localparam int M2   = (M1 > MODE_W) ? M1 : MODE_W;
   localparam int M3   = (M2 > SELFTEST_W) ? M2 : SELFTEST_W;
   localparam int SR_W = (M3 > PARSCAN_W) ? M3 : PARSCAN_W;

   if (REV_W < 1 || MODE_W < 1 || SELFTEST_W < 1 || PARSCAN_W < 1) begin : g_bad_len
      $error("tap_dr_path: register lengths must be positive");
   end

   function automatic int len_of(input dr_sel_e s);
      case (s)
         DSEL_IDENT:    return ID_W;
         DSEL_REV:      return REV_W;
         DSEL_MODE:     return MODE_W;
         DSEL_SELFTEST: return SELFTEST_W;
         DSEL_PARSCAN:  return PARSCAN_W;
         default:       return 1;
      endcase
   endfunction

   logic [SR_W-1:0]       sr_q, sr_cap, sr_sh, sr_up;
   logic [MODE_W-1:0]     mode_q;
   logic [SELFTEST_W-1:0] st_q;
   logic [PARSCAN_W-1:0]  ps_q;
   int                    cur_len;

   assign cur_len = len_of(sel);
   assign sr_up   = {1'b0, sr_q[SR_W-1:1]};

   always_comb begin
      sr_cap = '0;
      case (sel)
         DSEL_IDENT:    sr_cap[ID_W-1:0]       = IDENT_VAL;
         DSEL_REV:      sr_cap[REV_W-1:0]      = REV_VAL;
         DSEL_MODE:     sr_cap[MODE_W-1:0]     = mode_q;
         DSEL_SELFTEST: sr_cap[SELFTEST_W-1:0] = st_q;
         DSEL_PARSCAN:  sr_cap[PARSCAN_W-1:0]  = ps_q;
         default:       sr_cap = '0;
      endcase
   end

   // variable-length shift: tdi enters at bit (length-1)
   always_comb begin
      for (int i = 0; i < SR_W; i++) begin
         sr_sh[i] = (i == cur_len - 1) ? tdi : sr_up[i];
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 sr_q <= '0;
      else if (state == ST_CAP_DR) sr_q <= sr_cap;
      else if (state == ST_SH_DR)  sr_q <= sr_sh;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         mode_q <= '0;
         st_q   <= '0;
      end else if (state == ST_UPD_DR) begin
         if (sel == DSEL_MODE)     mode_q <= sr_q[MODE_W-1:0];
         if (sel == DSEL_SELFTEST) st_q   <= sr_q[SELFTEST_W-1:0];
      end
   end

   if (HOLD_PARSCAN) begin : g_ps_hold
      always_ff @(posedge tck or negedge trst_n) begin
         if (!trst_n)                                        ps_q <= '0;
         else if (state == ST_UPD_DR && sel == DSEL_PARSCAN) ps_q <= sr_q[PARSCAN_W-1:0];
      end
   end else begin : g_ps_zero
      assign ps_q = '0;
   end

   assign sh_lsb = sr_q[0];

   AST_REV_CAPTURE: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && sel == DSEL_REV) |=> (sr_q[REV_W-1:0] == REV_VAL)); // R7

   AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_CAP_DR && sel == DSEL_BYPASS) |=> (sr_q[0] == 1'b0)); // R5

endmodule

// File: rtl/jtag_field_tap.sv
`timescale 1ns/1ps
module jtag_field_tap
   import tap_fld_pkg::*;
#(
   parameter logic [31:0] IDENT_VAL  = 32'h0D5A1003,
   parameter logic [7:0]  REV_VAL    = 8'h10,
   parameter int          MODE_W     = 8,
   parameter int          SELFTEST_W = 29,
   parameter int          PARSCAN_W  = 441
)(
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_oe,
   output logic test_mode_n,
   output logic out_dis_n,
   output logic pad_bscan_n,
   output logic core_bscan_n,
   output logic tristate_all
);

   tap_state_e        state;
   dr_sel_e           sel;
   logic [IR_W-1:0]   ir_q;
   logic              ir_lsb, dr_lsb, in_tlr;

   tap_fsm u_fsm (
      .tck(tck), .trst_n(trst_n), .tms(tms), .state(state)
   );

   tap_ir #(.W(IR_W)) u_ir (
      .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
      .sh_lsb(ir_lsb), .ir_q(ir_q), .sel(sel)
   );

   tap_dr_path #(
      .IDENT_VAL(IDENT_VAL), .REV_W(8), .REV_VAL(REV_VAL), .MODE_W(MODE_W),
      .SELFTEST_W(SELFTEST_W), .PARSCAN_W(PARSCAN_W), .HOLD_PARSCAN(1'b1)
   ) u_dr (
      .tck(tck), .trst_n(trst_n), .state(state), .sel(sel), .tdi(tdi),
      .sh_lsb(dr_lsb)
   );

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo_oe <= (state == ST_SH_IR) || (state == ST_SH_DR);
         if (state == ST_SH_IR)      tdo <= ir_lsb;
         else if (state == ST_SH_DR) tdo <= dr_lsb;
      end
   end

   assign in_tlr       = (state == ST_TLR);
   assign test_mode_n  = in_tlr | ir_q[B_TEST_N];
   assign out_dis_n    = in_tlr | ir_q[B_OUTDIS_N];
   assign pad_bscan_n  = in_tlr | ir_q[B_PAD_N];
   assign core_bscan_n = in_tlr | ir_q[B_CORE_N];
   assign tristate_all = ~out_dis_n;

   AST_TDO_OE_SHIFT: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe |-> (state == ST_SH_IR || state == ST_SH_DR)); // R4

   AST_HIZ_TRISTATE: assert property (@(posedge tck) disable iff (!trst_n)
      (!in_tlr && ir_q == OP_HIZ) |-> (tristate_all && !out_dis_n)); // R9

endmodule

// File: tb/jtag_field_tap_test.sv
`timescale 1ns/1ps
module jtag_field_tap_test;

   logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic tdo, tdo_oe, test_mode_n, out_dis_n, pad_bscan_n, core_bscan_n, tristate_all;
   int   checks = 0, errors = 0;
   bit   done = 1'b0;

   always #2 tck = ~tck; // 250 MHz

   jtag_field_tap uut (
      .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
      .test_mode_n(test_mode_n), .out_dis_n(out_dis_n), .pad_bscan_n(pad_bscan_n),
      .core_bscan_n(core_bscan_n), .tristate_all(tristate_all)
   );

   task automatic chk(input bit ok, input string req, input logic [511:0] act,
                      input logic [511:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ctl();
      return {test_mode_n, out_dis_n, pad_bscan_n, core_bscan_n};
   endfunction

   // one clock: sample tdo after the falling edge, then drive for the next rise
   task automatic step(input logic m, input logic d, output logic o, output logic oe);
      @(negedge tck);
      #1;
      o   = tdo;
      oe  = tdo_oe;
      tms = m;
      tdi = d;
   endtask

   task automatic idle();
      logic o, oe;
      step(1'b0, 1'b0, o, oe);
   endtask

   // from Run-Test-Idle, back to Run-Test-Idle
   task automatic scan_ir(input logic [24:0] din, output logic [24:0] dout);
      logic o, oe;
      logic [3:0] snap;
      snap = ctl();
      step(1, 0, o, oe); step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
      for (int i = 0; i < 25; i++) begin
         step(i == 24, din[i], o, oe);
         dout[i] = o;
         if (!oe) chk(1'b0, "R4 oe in Shift-IR", oe, 1);
         if (ctl() != snap) chk(1'b0, "R11 controls before Update-IR", ctl(), snap);
      end
      step(1, 0, o, oe);
      if (oe) chk(1'b0, "R4 oe off in Exit1-IR", oe, 0);
      step(0, 0, o, oe);
      idle();
   endtask

   task automatic scan_dr(input int len, input logic [511:0] din, output logic [511:0] dout);
      logic o, oe;
      dout = '0;
      step(1, 0, o, oe); step(0, 0, o, oe); step(0, 0, o, oe);
      for (int i = 0; i < len; i++) begin
         step(i == len - 1, din[i], o, oe);
         dout[i] = o;
         if (!oe) chk(1'b0, "R4 oe in Shift-DR", oe, 1);
      end
      step(1, 0, o, oe);
      step(0, 0, o, oe);
      idle();
   endtask

   function automatic logic [511:0] mask(input int len, input logic [511:0] v);
      logic [511:0] r;
      r = '0;
      for (int i = 0; i < len; i++) r[i] = v[i];
      return r;
   endfunction

   task automatic t_reset();
      logic [511:0] q;
      trst_n = 1'b0;
      #7;
      chk(ctl() == 4'hF && !tristate_all, "R1 controls in reset", ctl(), 4'hF);
      chk(tdo_oe == 1'b0, "R1 oe in reset", tdo_oe, 0);
      trst_n = 1'b1;
      idle(); idle();
      chk(tdo_oe == 1'b0, "R4 oe idle", tdo_oe, 0);
      scan_dr(32, '0, q);
      chk(q[31:0] == 32'h0D5A1003, "R1 default ident", q[31:0], 32'h0D5A1003);
   endtask

   task automatic t_ir_capture();
      logic [24:0] c;
      scan_ir(25'h1FFFFFE, c);
      chk(c == 25'h0000001, "R3 IR capture", c, 25'h1);
   endtask

   task automatic t_ident();
      logic [511:0] q;
      scan_dr(32, 512'hFFFF_0000, q);
      chk(q[31:0] == 32'h0D5A1003, "R6 ident capture", q[31:0], 32'h0D5A1003);
   endtask

   task automatic t_bypass(input logic [24:0] op, input string req);
      logic [24:0] c;
      logic [511:0] q, d, e;
      scan_ir(op, c);
      d = 512'hB5;
      scan_dr(8, d, q);
      e = mask(8, {d[510:0], 1'b0});
      chk(q[7:0] == e[7:0], req, q[7:0], e[7:0]);
   endtask

   task automatic t_rev();
      logic [24:0] c;
      logic [511:0] q;
      scan_ir(25'h127FFFA, c);
      scan_dr(8, 512'h5A, q);
      chk(q[7:0] == 8'h10, "R7 revision first", q[7:0], 8'h10);
      scan_dr(8, 512'hC3, q);
      chk(q[7:0] == 8'h10, "R7 revision ignores writes", q[7:0], 8'h10);
   endtask

   task automatic t_mode();
      logic [24:0] c;
      logic [511:0] q;
      scan_ir(25'h123FFFA, c);
      scan_dr(8, 512'hA5, q);
      chk(q[7:0] == 8'h00, "R8 mode reset value", q[7:0], 8'h00);
      scan_dr(8, 512'h3C, q);
      chk(q[7:0] == 8'hA5, "R8 mode readback", q[7:0], 8'hA5);
      scan_dr(8, 512'h00, q);
      chk(q[7:0] == 8'h3C, "R8 mode second readback", q[7:0], 8'h3C);
   endtask

   task automatic t_hiz();
      logic [24:0] c;
      logic [511:0] q;
      chk(!tristate_all, "R9 tristate before", tristate_all, 0);
      scan_ir(25'h1FFFFDF, c);
      chk(tristate_all && !out_dis_n, "R9 tristate after update", {tristate_all, out_dis_n}, 2'b10);
      chk(test_mode_n && pad_bscan_n && core_bscan_n, "R11 other controls idle",
          ctl(), 4'b1011);
      scan_dr(4, 512'hF, q);
      chk(q[3:0] == 4'b1110, "R9 one-bit register", q[3:0], 4'b1110);
   endtask

   task automatic t_tms_reset();
      logic o, oe;
      logic [511:0] q;
      for (int i = 0; i < 5; i++) step(1, 0, o, oe);
      step(0, 0, o, oe);
      chk(ctl() == 4'hF && !tristate_all, "R2 controls released", ctl(), 4'hF);
      idle();
      scan_dr(32, '0, q);
      chk(q[31:0] == 32'h0D5A1003, "R2 ident restored", q[31:0], 32'h0D5A1003);
   endtask

   task automatic t_ctl_bits();
      logic [24:0] c;
      scan_ir(25'h1FFFFA7, c);
      chk(ctl() == 4'b0100 && !tristate_all, "R11 bits 6,4,3 low", ctl(), 4'b0100);
      scan_ir(25'h1FFFEB0, c);
      chk(ctl() == 4'b0110, "R11 parallel-scan code bits", ctl(), 4'b0110);
   endtask

   task automatic t_loopback(input logic [24:0] op, input int len, input string req);
      logic [24:0] c;
      logic [511:0] q, p1, p2;
      p1 = mask(len, {16{32'hC3A5_1E97}});
      p2 = mask(len, {16{32'h5F0A_9B61}});
      scan_ir(op, c);
      scan_dr(len, p1, q);
      chk(q == '0, {req, " reset value"}, q, 0);
      scan_dr(len, p2, q);
      chk(q == p1, {req, " readback"}, q, p1);
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_ir_capture();
      t_ident();
      t_bypass(25'h1FFFFFF, "R5 all-ones bypass");
      t_bypass(25'h1FFFFFC, "R5 unlisted code bypass");
      t_bypass(25'h0FFFFFE, "R5 bit24-low bypass");
      t_rev();
      t_mode();
      t_hiz();
      t_tms_reset();
      t_ctl_bits();
      t_loopback(25'h1FFFFFD, 29, "R10 self-test register");
      t_loopback(25'h1FFFEB0, 441, "R10 parallel scan register");
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule